// File: doc/BRIEF.md
# Host-Bus Slave Shutdown Controller

This block decides when a host-bus slave interface (for example a low-pin-count host port) has to be held in reset to save power. It has two independent ways to do so. In the first, firmware arms an enable bit, and a falling edge on the active-low power-down pin then puts the slave into hardware shutdown at once. A rising edge on the same pin ends it and disarms the enable bit by itself. In the second, firmware sets a software-shutdown bit. That shutdown stays in force through pin activity and ends only when firmware writes the bit to 0 or the bus reset is asserted.

The block drives an active-low interface reset that is asserted while either shutdown is in force or while the bus reset is asserted. Every falling edge of the power-down pin sets a sticky shutdown flag. The flag can raise an interrupt request. Firmware clears the flag with a read followed by a write of 0. A read-only status bit gives the synchronised pin level. During preparation, firmware can use that bit to see whether the pin has already risen and then disarm the enable bit. Both pins pass through two-flop synchronisers before any edge is detected. A small register port, with a combinational read path, holds the control and status bits.

Register map: CTRL sits at address 0 and STAT at address 1. All other addresses read as 0, and writes to them are ignored.

Top module: `bus_shutdown_ctrl`

## Requirements
- R1: After the synchronous reset, CTRL reads 0, STAT reads 2 (pin level high, flag clear, no hardware shutdown), `if_rst_n` is 1 and `shdn_irq` is 0.
- R2: STAT bit 1 shows the power-down pin through two flops: a pin change made before clock edge k first appears after edge k+1.
- R3: With CTRL bit 0 (hardware-shutdown enable) at 1, a falling pin change made before edge k drives `if_rst_n` low after edge k+2, and STAT bit 2 reads 1. With the enable at 0, a falling edge causes no shutdown.
- R4: A rising edge of the pin clears CTRL bit 0 and ends hardware shutdown on the same clock edge. If a register write and this automatic clear land on the same edge, the automatic clear wins.
- R5: Writing CTRL bit 1 (software shutdown) to 1 drives `if_rst_n` low from the next cycle. Rising or falling edges of the pin do not clear it.
- R6: A CTRL write with bit 0 at 1 clears CTRL bit 1, whatever value bit 1 carries in that write.
- R7: While the synchronised bus reset is low, `if_rst_n` is held low and CTRL bit 1 is cleared. `if_rst_n` returns high once the bus reset is released, as long as no shutdown is in force.
- R8: Every falling edge of the pin sets STAT bit 0 (the shutdown flag), whatever value CTRL bit 0 holds.
- R9: Writing 0 to STAT bit 0 clears the flag only if a STAT read since the flag was last set returned the flag as 1. Otherwise the write leaves the flag set.
- R10: `shdn_irq` equals the flag ANDed with CTRL bit 2 (interrupt enable).
- R11: Writing CTRL bit 0 to 0 during hardware shutdown ends the shutdown on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| pd_pin_n | input | 1 | Asynchronous active-low power-down pin |
| bus_rst_n | input | 1 | Asynchronous active-low bus reset pin |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (used for flag-clear qualification) |
| reg_addr | input | ADDR_W | Register address (0 CTRL, 1 STAT) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational register read data |
| if_rst_n | output | 1 | Active-low reset to the bus interface |
| shdn_irq | output | 1 | Shutdown-flag interrupt request |

## Verification
The hardest situation to reach is a pin rising edge that coincides with software shutdown already in force while the bus reset is released. It shows that only the hardware path lets go. To reach it, the stimulus first writes the software bit and then drives a full low-then-high pulse on the pin. The flag-clear handshake is awkward as well, because the write of 0 has to land both with and without a qualifying read before it. The stimulus orders these accesses explicitly. A reference model in the bench follows the synchroniser delays cycle by cycle, so an early or late release of `if_rst_n` shows up on the exact clock where it happens.

// File: rtl/shdn_pkg.sv
// Package: shared field positions and the control register type for the
// shutdown controller. Assumes DATA_W of the register port is at least 3.
package shdn_pkg;

    localparam int CTRL_HW_EN  = 0;
    localparam int CTRL_SW     = 1;
    localparam int CTRL_IRQ_EN = 2;

    localparam int STAT_FLAG   = 0;
    localparam int STAT_LEVEL  = 1;
    localparam int STAT_HW     = 2;

    typedef struct packed {
        logic irq_en;
        logic sw_shdn;
        logic hw_en;
    } ctrl_t;

endpackage

// File: rtl/pin_sync.sv
// Module: pin_sync
// Brings an asynchronous pin into the clock domain through a flop chain and
// produces one-clock pulses on each level change of the synchronised value.
// Assumes STAGES >= 2; RST_VAL is the idle level of the pin.
module pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic fall,
    output logic rise
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the pin through the chain and keep the last synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
            prev_q  <= RST_VAL;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign fall  = prev_q & ~level;
    assign rise  = ~prev_q & level;

endmodule

// File: rtl/shdn_core.sv
// Module: shdn_core
// Holds the hardware-shutdown state. It enters on a falling edge while the
// enable bit is armed and leaves on a rising edge or when firmware disarms.
// Assumes edge inputs are single-clock pulses from pin_sync.
module shdn_core (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_en,
    input  logic pd_fall,
    input  logic pd_rise,
    input  logic en_off_wr,
    output logic hw_shdn
);

    logic hw_shdn_q;

    // Track hardware shutdown; release conditions take priority over entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_shdn_q <= 1'b0;
        end else if (pd_rise || en_off_wr) begin
            hw_shdn_q <= 1'b0;
        end else if (pd_fall && hw_en) begin
            hw_shdn_q <= 1'b1;
        end
    end

    assign hw_shdn = hw_shdn_q;

endmodule

// File: rtl/shdn_regs.sv
// Module: shdn_regs
// Control and status registers: the enable, software-shutdown and interrupt
// enable bits with their automatic clears, plus the sticky shutdown flag and
// its read-then-write-zero clear. Read data is combinational.
// Assumes DATA_W >= 3.
module shdn_regs
    import shdn_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 8,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pd_fall,
    input  logic              pd_rise,
    input  logic              pd_level,
    input  logic              bus_rst_act,
    input  logic              hw_shdn,
    output ctrl_t             ctrl,
    output logic              flag,
    output logic              en_off_wr,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    ctrl_t ctrl_q;
    logic  flag_q;
    logic  armed_q;
    logic  wr_ctrl;
    logic  wr_stat;
    logic  rd_stat;

    assign wr_ctrl   = wr_en && (addr == A_CTRL);
    assign wr_stat   = wr_en && (addr == A_STAT);
    assign rd_stat   = rd_en && (addr == A_STAT);
    assign en_off_wr = wr_ctrl && !wdata[CTRL_HW_EN];

    // Control bits: firmware writes first, automatic clears override them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.irq_en  <= wdata[CTRL_IRQ_EN];
                ctrl_q.hw_en   <= wdata[CTRL_HW_EN];
                ctrl_q.sw_shdn <= wdata[CTRL_SW] & ~wdata[CTRL_HW_EN];
            end
            if (pd_rise) begin
                ctrl_q.hw_en <= 1'b0;
            end
            if (bus_rst_act) begin
                ctrl_q.sw_shdn <= 1'b0;
            end
        end
    end

    // Sticky flag with read-qualified clear; a new falling edge re-arms it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (pd_fall) begin
            flag_q  <= 1'b1;
            armed_q <= 1'b0;
        end else if (wr_stat && !wdata[STAT_FLAG] && armed_q) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (rd_stat && flag_q) begin
            armed_q <= 1'b1;
        end
    end

    // Read multiplexer for the two registers.
    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata[CTRL_HW_EN]  = ctrl_q.hw_en;
            rdata[CTRL_SW]     = ctrl_q.sw_shdn;
            rdata[CTRL_IRQ_EN] = ctrl_q.irq_en;
        end else if (addr == A_STAT) begin
            rdata[STAT_FLAG]   = flag_q;
            rdata[STAT_LEVEL]  = pd_level;
            rdata[STAT_HW]     = hw_shdn;
        end
    end

    assign ctrl = ctrl_q;
    assign flag = flag_q;

endmodule

// File: rtl/bus_shutdown_ctrl.sv
// Module: bus_shutdown_ctrl (top)
// Synchronises the power-down and bus reset pins, runs the hardware-shutdown
// state, and combines both shutdown paths with the bus reset into the
// interface reset. Assumes both pins idle high and SYNC_STAGES >= 2.
module bus_shutdown_ctrl
    import shdn_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8,
    parameter int CTRL_ADDR   = 0,
    parameter int STAT_ADDR   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_pin_n,
    input  logic              bus_rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              if_rst_n,
    output logic              shdn_irq
);

    localparam int NPINS = 2;

    logic [NPINS-1:0] pin_in;
    logic [NPINS-1:0] pin_lvl;
    logic [NPINS-1:0] pin_fall;
    logic [NPINS-1:0] pin_rise;

    logic  pd_level;
    logic  pd_fall;
    logic  pd_rise;
    logic  bus_rst_act;
    logic  hw_shdn;
    logic  flag;
    logic  en_off_wr;
    ctrl_t ctrl_q;

    assign pin_in = {bus_rst_n, pd_pin_n};

    // One synchroniser per incoming pin, both idling high.
    for (genvar g = 0; g < NPINS; g++) begin : g_sync
        pin_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(1'b1)
        ) i_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pin_in[g]),
            .level(pin_lvl[g]),
            .fall (pin_fall[g]),
            .rise (pin_rise[g])
        );
    end

    assign pd_level    = pin_lvl[0];
    assign pd_fall     = pin_fall[0];
    assign pd_rise     = pin_rise[0];
    assign bus_rst_act = ~pin_lvl[1];

    shdn_core i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_en    (ctrl_q.hw_en),
        .pd_fall  (pd_fall),
        .pd_rise  (pd_rise),
        .en_off_wr(en_off_wr),
        .hw_shdn  (hw_shdn)
    );

    shdn_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CTRL_ADDR(CTRL_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .rd_en      (reg_rd_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .pd_fall    (pd_fall),
        .pd_rise    (pd_rise),
        .pd_level   (pd_level),
        .bus_rst_act(bus_rst_act),
        .hw_shdn    (hw_shdn),
        .ctrl       (ctrl_q),
        .flag       (flag),
        .en_off_wr  (en_off_wr),
        .rdata      (reg_rdata)
    );

    assign if_rst_n = ~(hw_shdn | ctrl_q.sw_shdn | bus_rst_act);
    assign shdn_irq = flag & ctrl_q.irq_en;

endmodule

// File: rtl/shdn_checker.sv
// Module: shdn_checker
// Temporal properties of the shutdown controller, attached to the top module
// by the bind statement at the end of this file.
module shdn_checker (
    input logic clk,
    input logic rst_n,
    input logic pd_fall,
    input logic pd_rise,
    input logic bus_rst_act,
    input logic wr_ctrl,
    input logic wr_d0,
    input logic wr_stat_clr,
    input logic hw_en,
    input logic sw_shdn,
    input logic irq_en,
    input logic hw_shdn,
    input logic flag,
    input logic if_rst_n,
    input logic irq
);

    p_hw_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hw_shdn) |-> $past(hw_en) && $past(pd_fall));

    p_fall_enters_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_fall && hw_en && !wr_ctrl) |=> (hw_shdn && !if_rst_n));

    p_rise_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pd_rise |=> (!hw_en && !hw_shdn));

    p_sw_survives_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_shdn && pd_rise && !wr_ctrl && !bus_rst_act) |=> sw_shdn);

    p_en_clears_sw_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wr_d0) |=> !sw_shdn);

    p_bus_rst_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_act |-> !if_rst_n);

    p_bus_rst_clears_sw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_act |=> !sw_shdn);

    p_flag_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pd_fall |=> flag);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_stat_clr) |=> flag);

    p_irq_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_fall && irq_en && !wr_ctrl) |=> irq);

    p_disarm_releases_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wr_d0) |=> !hw_shdn);

endmodule

bind bus_shutdown_ctrl shdn_checker i_shdn_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd_fall    (pd_fall),
    .pd_rise    (pd_rise),
    .bus_rst_act(bus_rst_act),
    .wr_ctrl    (reg_wr_en && (reg_addr == ADDR_W'(CTRL_ADDR))),
    .wr_d0      (reg_wdata[0]),
    .wr_stat_clr(reg_wr_en && (reg_addr == ADDR_W'(STAT_ADDR)) && !reg_wdata[0]),
    .hw_en      (ctrl_q.hw_en),
    .sw_shdn    (ctrl_q.sw_shdn),
    .irq_en     (ctrl_q.irq_en),
    .hw_shdn    (hw_shdn),
    .flag       (flag),
    .if_rst_n   (if_rst_n),
    .irq        (shdn_irq)
);

// File: tb/test_bus_shutdown_ctrl.sv
// Bench for bus_shutdown_ctrl: a behavioural reference model is stepped on
// every rising edge and compared with the outputs on every falling edge,
// alongside directed register checks that use hand-computed values.
module test_bus_shutdown_ctrl;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pd_pin_n = 1'b1;
    logic              bus_rst_n = 1'b1;
    logic              reg_wr_en = 1'b0;
    logic              reg_rd_en = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              if_rst_n;
    logic              shdn_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bus_shutdown_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bus_shutdown_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_pin_n (pd_pin_n),
        .bus_rst_n(bus_rst_n),
        .reg_wr_en(reg_wr_en),
        .reg_rd_en(reg_rd_en),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .if_rst_n (if_rst_n),
        .shdn_irq (shdn_irq)
    );

    // ---------------- reference model ----------------
    bit pq[$];
    bit bq[$];
    bit m_hw_en, m_sw, m_irq_en, m_hw, m_flag, m_armed;

    function automatic void model_clear();
        pq = '{1'b1, 1'b1, 1'b1};
        bq = '{1'b1, 1'b1, 1'b1};
        m_hw_en = 0; m_sw = 0; m_irq_en = 0; m_hw = 0; m_flag = 0; m_armed = 0;
    endfunction

    initial model_clear();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_clear();
        end else begin
            bit fall_e, rise_e, brst_e, wc, ws;
            bit n_hw_en, n_sw, n_irq_en, n_hw;
            fall_e = pq[0] && !pq[1];
            rise_e = !pq[0] && pq[1];
            brst_e = !bq[1];
            wc = reg_wr_en && (reg_addr == 0);
            ws = reg_wr_en && (reg_addr == 1);
            n_hw_en = m_hw_en; n_sw = m_sw; n_irq_en = m_irq_en; n_hw = m_hw;
            if (wc) begin
                n_hw_en = reg_wdata[0];
                n_sw = reg_wdata[0] ? 1'b0 : reg_wdata[1];
                n_irq_en = reg_wdata[2];
            end
            if (rise_e) n_hw_en = 0;
            if (brst_e) n_sw = 0;
            if (rise_e || (wc && !reg_wdata[0])) n_hw = 0;
            else if (fall_e && m_hw_en) n_hw = 1;
            if (fall_e) begin
                m_flag = 1; m_armed = 0;
            end else if (ws && !reg_wdata[0] && m_armed) begin
                m_flag = 0; m_armed = 0;
            end else if (reg_rd_en && reg_addr == 1 && m_flag) begin
                m_armed = 1;
            end
            m_hw_en = n_hw_en; m_sw = n_sw; m_irq_en = n_irq_en; m_hw = n_hw;
            void'(pq.pop_front()); pq.push_back(pd_pin_n);
            void'(bq.pop_front()); bq.push_back(bus_rst_n);
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison of the outputs against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 R5 R7 if_rst_n", int'(if_rst_n),
                int'(!(m_hw || m_sw || !bq[1])));
            chk("R10 shdn_irq", int'(shdn_irq), int'(m_flag && m_irq_en));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr = ADDR_W'(a); reg_wdata = DATA_W'(d); reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        @(negedge clk);
        reg_addr = ADDR_W'(a); reg_rd_en = 1'b1;
        #1;
        chk(req, int'(reg_rdata), exp);
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic set_pd(input bit v, input int n);
        @(negedge clk);
        pd_pin_n = v;
        repeat (n) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 if_rst_n", int'(if_rst_n), 1);
        chk("R1 irq", int'(shdn_irq), 0);
        rd_chk("R1 CTRL", 0, 0);
        rd_chk("R1 STAT", 1, 2);

        // R2 and R8: synchroniser latency, flag set without the enable
        @(negedge clk);
        reg_addr = 1; pd_pin_n = 1'b0;
        @(negedge clk);
        chk("R2 level after one edge", int'(reg_rdata[1]), 1);
        @(negedge clk);
        chk("R2 level after two edges", int'(reg_rdata[1]), 0);
        chk("R8 flag not yet", int'(reg_rdata[0]), 0);
        @(negedge clk);
        chk("R8 flag set", int'(reg_rdata[0]), 1);
        repeat (2) @(negedge clk);
        chk("R3 no shutdown when disarmed", int'(if_rst_n), 1);
        chk("R10 irq masked", int'(shdn_irq), 0);

        // R9: clear needs a prior read
        wr(1, 0);
        rd_chk("R9 write 0 without read ignored", 1, 1);
        wr(1, 0);
        rd_chk("R9 cleared after read", 1, 0);
        set_pd(1'b1, 5);
        rd_chk("R2 level high again", 1, 2);

        // R3 and R4: hardware shutdown
        wr(0, 1);
        rd_chk("R3 enable armed", 0, 1);
        @(negedge clk);
        pd_pin_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R3 not yet low", int'(if_rst_n), 1);
        @(negedge clk);
        chk("R3 low after third edge", int'(if_rst_n), 0);
        repeat (2) @(negedge clk);
        rd_chk("R3 STAT shutdown", 1, 5);
        set_pd(1'b1, 5);
        chk("R4 released", int'(if_rst_n), 1);
        rd_chk("R4 enable auto-cleared", 0, 0);
        rd_chk("R4 STAT after release", 1, 3);
        wr(1, 0);

        // R5: software shutdown survives pin edges
        wr(0, 2);
        chk("R5 low after write", int'(if_rst_n), 0);
        set_pd(1'b0, 5);
        set_pd(1'b1, 5);
        chk("R5 still low after rise", int'(if_rst_n), 0);
        rd_chk("R5 CTRL kept", 0, 2);

        // R6: arming the enable clears the software bit
        wr(0, 3);
        rd_chk("R6 software bit cleared", 0, 1);
        chk("R6 interface released", int'(if_rst_n), 1);

        // R11: disarm during hardware shutdown
        set_pd(1'b0, 5);
        chk("R11 in shutdown", int'(if_rst_n), 0);
        wr(0, 0);
        chk("R11 released by disarm", int'(if_rst_n), 1);
        rd_chk("R11 STAT", 1, 1);
        set_pd(1'b1, 5);
        rd_chk("R9 read before clear", 1, 3);
        wr(1, 0);

        // R7: bus reset
        wr(0, 2);
        @(negedge clk);
        bus_rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 held low", int'(if_rst_n), 0);
        rd_chk("R7 software bit cleared", 0, 0);
        chk("R7 still low while asserted", int'(if_rst_n), 0);
        @(negedge clk);
        bus_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 released", int'(if_rst_n), 1);

        // R10: interrupt follows the flag when enabled
        wr(0, 4);
        set_pd(1'b0, 5);
        chk("R10 irq raised", int'(shdn_irq), 1);
        rd_chk("R10 STAT", 1, 1);
        wr(1, 0);
        chk("R10 irq dropped", int'(shdn_irq), 0);
        set_pd(1'b1, 5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule